// File: doc/BRIEF.md
# Transmit Character Parity Screen

This block is the input stage of one transmit lane that carries characters which are already line-coded. On every edge of the input clock it captures a 10-bit character together with one parity bit. A small dual-clock phase-align buffer then carries the character into the character-clock domain. There it is screened. If parity checking is on and the 11 captured bits hold an even number of ones, the character is replaced by a fixed illegal code. The far receiver then reports a code violation instead of accepting corrupted data. Clean characters are forwarded unchanged to the serializer-facing output.

A single status output is shared by three sources. The first is a one-cycle parity-error pulse, aligned with the replaced character. The second is a one-cycle pulse at the end of every self-test pass. The third is a sticky flag set by phase-align buffer overflow or underflow. The sticky flag is cleared by a word-sync strobe from upstream logic, or by the synchronous reset, which also re-centres the buffer. A parameter can remove the buffer; characters are then captured directly on the character clock.

Top module: `tx_parity_screen`

## Requirements
- R1: Parity is odd. A character is bad when the XOR of `in_par` and all ten `in_data` bits is 0. While checking is on (`par_chk_n` = 0), every bad character raises `tx_stat` and every good one leaves it low (when no other source is active).
- R2: While `par_chk_n` = 0, a bad character is forwarded on `tx_char` as the code 10'b1001111000 (bit 9 first), not as its own data.
- R3: While `par_chk_n` = 1, every character reaches `tx_char` unchanged and never raises the parity pulse.
- R4: The parity pulse lasts one character clock and is high in the same cycle that the replaced character is on `tx_char`.
- R5: Characters leave in the order they were captured. With equal-frequency clocks, the delay from the capture edge is fixed at BUF_DEPTH/2 + 2 character clock edges for the buffer read, plus 1 edge for screening.
- R6: While `bist_en` = 1, `tx_stat` pulses for one cycle after every PASS_LEN-th enabled character clock edge. The first pulse comes after edge PASS_LEN. Dropping `bist_en` returns the pass count to zero.
- R7: If the reader's view of the write pointer catches up with the read pointer (buffer underflow), `tx_stat` goes high and stays high.
- R8: If the writer's view of the buffer fill reaches BUF_DEPTH (buffer overflow), `tx_stat` goes high and stays high.
- R9: A one-cycle `wsync_done` pulse clears the sticky buffer fault when no new fault event arrives in the same cycle. A new fault event wins over the clear.
- R10: While `rst` is high, `tx_char` and `tx_stat` are 0 and the sticky fault is cleared. Releasing `rst` re-centres the buffer so that the R5 delay holds again.
- R11: `tx_stat` is the OR of the parity pulse, the self-test pulse and the sticky fault. While the fault is held, `tx_stat` stays high whatever the characters are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Input capture clock, same frequency as chr_clk, any phase |
| chr_clk | input | 1 | Character clock of the serializer side |
| rst | input | 1 | Synchronous active-high reset, must be seen by both clocks |
| in_data | input | 10 | Pre-encoded character |
| in_par | input | 1 | Odd-parity bit for in_data |
| par_chk_n | input | 1 | 0 enables parity screening, 1 passes characters unchanged |
| bist_en | input | 1 | Self-test progress counting enable (chr_clk domain) |
| wsync_done | input | 1 | Word-sync sequence completed; clears the sticky fault |
| tx_char | output | 10 | Screened character to the serializer |
| tx_stat | output | 1 | Shared status: parity pulse, self-test pulse, buffer fault |

## Verification
The bench builds the block with ALIGN_BUF=1, BUF_DEPTH=8, PASS_LEN=511 and SYNC_STAGES=2. With a depth of eight, the centred buffer has two entries of margin on the read side and three on the write side as seen through the synchronizers. Withholding four input clock edges therefore drives an underflow, and adding five extra edges drives an overflow. With a full-length pass of 511, two complete self-test periods fit in about a thousand cycles. This also exposes a counter that fails to restart after `bist_en` drops. The fixed delay of seven input iterations lets each random character be compared one for one against its screened result.

// File: rtl/txps_pkg.sv
package txps_pkg;

  localparam int CHAR_W = 10;

  // Illegal code forced onto the line when a character fails parity
  localparam logic [CHAR_W-1:0] POISON_CODE = 10'b1001111000;

  typedef struct packed {
    logic              par;
    logic [CHAR_W-1:0] data;
  } txps_word_t;

  // Parity-clean filler used before real characters arrive
  localparam txps_word_t IDLE_WORD = '{par: 1'b1, data: '0};

endpackage

// File: rtl/txps_align_fifo.sv
module txps_align_fifo
  import txps_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       wr_clk,
  input  logic       rd_clk,
  input  logic       rst,
  input  txps_word_t wr_word,
  output txps_word_t rd_word,
  output logic       ovf_lvl,
  output logic       udf_evt
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] CENTRE = PW'(DEPTH / 2);
  localparam logic [PW-1:0] FULL   = PW'(DEPTH);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  txps_word_t    mem [DEPTH];
  txps_word_t    cap_q;
  logic [PW-1:0] wbin_q, wgray_q, rg_s1_q, rg_s2_q, wseen;
  logic [PW-1:0] rbin_q, rgray_q, wg_s1_q, wg_s2_q, rseen;
  logic          fresh_q;

  // ---------------- write side (input clock) ----------------
  assign wseen = wbin_q - from_gray(rg_s2_q);

  always_ff @(posedge wr_clk) begin
    if (rst) begin
      cap_q   <= IDLE_WORD;
      wbin_q  <= CENTRE;
      wgray_q <= to_gray(CENTRE);
      rg_s1_q <= '0;
      rg_s2_q <= '0;
      ovf_lvl <= 1'b0;
    end else begin
      cap_q   <= wr_word;
      wbin_q  <= wbin_q + 1'b1;
      wgray_q <= to_gray(wbin_q + 1'b1);
      rg_s1_q <= rgray_q;
      rg_s2_q <= rg_s1_q;
      ovf_lvl <= (wseen >= FULL);
    end
  end

  always_ff @(posedge wr_clk) begin
    if (!rst) begin
      mem[wbin_q[AW-1:0]] <= cap_q;
    end
  end

  // ---------------- read side (character clock) ----------------
  assign rseen = from_gray(wg_s2_q) - rbin_q;

  always_ff @(posedge rd_clk) begin
    if (rst) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      wg_s1_q <= to_gray(CENTRE);
      wg_s2_q <= to_gray(CENTRE);
      fresh_q <= 1'b1;
      udf_evt <= 1'b0;
      rd_word <= IDLE_WORD;
    end else begin
      rbin_q  <= rbin_q + 1'b1;
      rgray_q <= to_gray(rbin_q + 1'b1);
      wg_s1_q <= wgray_q;
      wg_s2_q <= wg_s1_q;
      fresh_q <= fresh_q && (rbin_q != CENTRE - 1'b1);
      rd_word <= fresh_q ? IDLE_WORD : mem[rbin_q[AW-1:0]];
      udf_evt <= (rseen == '0);
    end
  end

endmodule

// File: rtl/txps_screen.sv
module txps_screen
  import txps_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  txps_word_t        word_in,
  input  logic              chk_n,
  output logic [CHAR_W-1:0] char_out,
  output logic              err_pulse
);

  logic odd_ok;
  logic swap;

  assign odd_ok = ^{word_in.par, word_in.data};
  assign swap   = !chk_n && !odd_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      char_out  <= '0;
      err_pulse <= 1'b0;
    end else begin
      char_out  <= swap ? POISON_CODE : word_in.data;
      err_pulse <= swap;
    end
  end

endmodule

// File: rtl/txps_pass_ctr.sv
module txps_pass_ctr #(
  parameter int PASS_LEN = 511
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic pass_pulse
);

  localparam int CW = $clog2(PASS_LEN);
  localparam logic [CW-1:0] LAST = CW'(PASS_LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q      <= '0;
      pass_pulse <= 1'b0;
    end else begin
      pass_pulse <= (cnt_q == LAST);
      cnt_q      <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/txps_fault_hold.sv
module txps_fault_hold #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ovf_lvl,
  input  logic udf_evt,
  input  logic clear,
  output logic fault_set,
  output logic fault_q
);

  logic [SYNC_STAGES-1:0] sync_q;

  // Synchronizer chain carrying the write-side overflow level across
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q[s] <= 1'b0;
      end else if (s == 0) begin
        sync_q[s] <= ovf_lvl;
      end else begin
        sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign fault_set = sync_q[SYNC_STAGES-1] | udf_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q <= 1'b0;
    end else begin
      fault_q <= fault_set | (fault_q & ~clear);
    end
  end

endmodule

// File: rtl/tx_parity_screen.sv
module tx_parity_screen
  import txps_pkg::*;
#(
  parameter int ALIGN_BUF   = 1,
  parameter int BUF_DEPTH   = 8,
  parameter int PASS_LEN    = 511,
  parameter int SYNC_STAGES = 2
) (
  input  logic              in_clk,
  input  logic              chr_clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              in_par,
  input  logic              par_chk_n,
  input  logic              bist_en,
  input  logic              wsync_done,
  output logic [CHAR_W-1:0] tx_char,
  output logic              tx_stat
);

  txps_word_t in_word;
  txps_word_t pipe_word;
  logic       ovf_lvl;
  logic       udf_evt;
  logic       fault_set;
  logic       fault_q;
  logic       err_pulse;
  logic       pass_pulse;

  assign in_word = '{par: in_par, data: in_data};

  if (ALIGN_BUF != 0) begin : g_buf
    txps_align_fifo #(
      .DEPTH(BUF_DEPTH)
    ) u_fifo (
      .wr_clk (in_clk),
      .rd_clk (chr_clk),
      .rst    (rst),
      .wr_word(in_word),
      .rd_word(pipe_word),
      .ovf_lvl(ovf_lvl),
      .udf_evt(udf_evt)
    );

    txps_fault_hold #(
      .SYNC_STAGES(SYNC_STAGES)
    ) u_fault (
      .clk      (chr_clk),
      .rst      (rst),
      .ovf_lvl  (ovf_lvl),
      .udf_evt  (udf_evt),
      .clear    (wsync_done),
      .fault_set(fault_set),
      .fault_q  (fault_q)
    );
  end else begin : g_direct
    always_ff @(posedge chr_clk) begin
      if (rst) pipe_word <= IDLE_WORD;
      else     pipe_word <= in_word;
    end
    assign ovf_lvl   = 1'b0;
    assign udf_evt   = 1'b0;
    assign fault_set = 1'b0;
    assign fault_q   = 1'b0;
  end

  txps_screen u_screen (
    .clk      (chr_clk),
    .rst      (rst),
    .word_in  (pipe_word),
    .chk_n    (par_chk_n),
    .char_out (tx_char),
    .err_pulse(err_pulse)
  );

  txps_pass_ctr #(
    .PASS_LEN(PASS_LEN)
  ) u_pass (
    .clk       (chr_clk),
    .rst       (rst),
    .en        (bist_en),
    .pass_pulse(pass_pulse)
  );

  assign tx_stat = err_pulse | pass_pulse | fault_q;

endmodule

// File: rtl/txps_checker.sv
module txps_checker
  import txps_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [CHAR_W-1:0] tx_char,
  input logic              tx_stat,
  input logic              par_chk_n,
  input logic              bist_en,
  input logic              wsync_done,
  input logic              err_pulse,
  input logic              pass_pulse,
  input logic              fault_set,
  input logic              fault_q
);

  // R2 / R4: a parity pulse always travels with the illegal code
  p_poison_r2: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (tx_char == POISON_CODE));

  // R3: screening off means no parity pulse
  p_quiet_off_r3: assert property (@(posedge clk) disable iff (rst)
    $past(par_chk_n) |-> !err_pulse);

  // R6: progress pulse is one cycle wide
  p_pass_single_r6: assert property (@(posedge clk) disable iff (rst)
    pass_pulse |=> !pass_pulse);

  // R6: no progress pulse without self-test
  p_pass_off_r6: assert property (@(posedge clk) disable iff (rst)
    !bist_en |=> !pass_pulse);

  // R7 / R8: fault holds until a clear
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (fault_q && !wsync_done) |=> fault_q);

  // R9: clear without new event drops the fault
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (wsync_done && !fault_set) |=> !fault_q);

  // R11: held fault is visible on the shared status
  p_stat_fault_r11: assert property (@(posedge clk) disable iff (rst)
    fault_q |-> tx_stat);

endmodule

bind tx_parity_screen txps_checker u_chk (
  .clk       (chr_clk),
  .rst       (rst),
  .tx_char   (tx_char),
  .tx_stat   (tx_stat),
  .par_chk_n (par_chk_n),
  .bist_en   (bist_en),
  .wsync_done(wsync_done),
  .err_pulse (err_pulse),
  .pass_pulse(pass_pulse),
  .fault_set (fault_set),
  .fault_q   (fault_q)
);

// File: tb/sim_tx_parity_screen.sv
module sim_tx_parity_screen;

  localparam int LAT = 7;  // input iterations from drive to observation, depth 8
  localparam logic [9:0] POISON_C = 10'b1001111000;

  logic       chr_clk = 1'b0;
  logic       in_raw = 1'b0;
  logic       in_gate = 1'b1;
  logic       in_xtra = 1'b0;
  logic       in_clk;
  logic       rst = 1'b1;
  logic [9:0] in_data = 10'd0;
  logic       in_par = 1'b1;
  logic       par_chk_n = 1'b0;
  logic       bist_en = 1'b0;
  logic       wsync_done = 1'b0;
  logic [9:0] tx_char;
  logic       tx_stat;

  int checks = 0;
  int fails = 0;
  int unsigned seed_v;
  logic [9:0] exp_c [512];
  logic       exp_s [512];
  string      tag_c [512];
  string      tag_s [512];

  assign in_clk = (in_raw & in_gate) | in_xtra;

  always #10 chr_clk = ~chr_clk;                  // 50 MHz, rising at 10+20k
  initial begin #5; forever #10 in_raw = ~in_raw; end  // rising at 15+20k

  tx_parity_screen #(
    .ALIGN_BUF(1), .BUF_DEPTH(8), .PASS_LEN(511), .SYNC_STAGES(2)
  ) u0 (
    .in_clk(in_clk), .chr_clk(chr_clk), .rst(rst),
    .in_data(in_data), .in_par(in_par), .par_chk_n(par_chk_n),
    .bist_en(bist_en), .wsync_done(wsync_done),
    .tx_char(tx_char), .tx_stat(tx_stat)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic is_bad(input logic [9:0] d, input logic p);
    return (^{p, d}) == 1'b0;
  endfunction

  task automatic wait_chr(input int n);
    repeat (n) @(negedge chr_clk);
  endtask

  task automatic run_chars(input int n, input logic chk_n, input bit directed, input int bad_pct);
    par_chk_n = chk_n;
    for (int k = 0; k < n; k++) begin
      logic [9:0] d;
      logic       p;
      @(negedge in_raw);
      if (k >= LAT) begin
        check(tx_char == exp_c[k-LAT], tag_c[k-LAT], 32'(tx_char), 32'(exp_c[k-LAT]));
        check(tx_stat == exp_s[k-LAT], tag_s[k-LAT], 32'(tx_stat), 32'(exp_s[k-LAT]));
      end
      d = 10'($urandom_range(0, 1023));
      p = ($urandom_range(0, 99) < bad_pct) ? (^d) : ~(^d);
      if (directed && k < 4) begin
        case (k)
          0: begin d = 10'h000; p = 1'b0; end
          1: begin d = 10'h3FF; p = 1'b1; end
          2: begin d = 10'h3FF; p = 1'b0; end
          default: begin d = POISON_C; p = 1'b0; end
        endcase
      end
      in_data = d;
      in_par  = p;
      if (!chk_n && is_bad(d, p)) begin
        exp_c[k] = POISON_C; exp_s[k] = 1'b1;
        tag_c[k] = "R2 char"; tag_s[k] = "R1 R4 stat";
      end else begin
        exp_c[k] = d; exp_s[k] = 1'b0;
        tag_c[k] = chk_n ? "R3 char" : "R5 char";
        tag_s[k] = chk_n ? "R3 stat" : "R1 stat";
      end
    end
    in_data = 10'd0;
    in_par  = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge in_raw);
    rst = 1'b1;
    repeat (3) @(negedge in_raw);
    check(tx_stat == 1'b0, "R10 stat in reset", 32'(tx_stat), 32'd0);
    check(tx_char == 10'd0, "R10 char in reset", 32'(tx_char), 32'd0);
    rst = 1'b0;  // released between an input edge and the next character edge
  endtask

  task automatic bist_window(input int len, input int label);
    int quiet_bad = 0;
    for (int n = 1; n <= len; n++) begin
      @(negedge chr_clk);
      if (n % 511 == 0) check(tx_stat == 1'b1, "R6 pass pulse", 32'(tx_stat), 32'd1);
      else if (tx_stat != 1'b0) quiet_bad++;
    end
    check(quiet_bad == 0, "R6 no stray pulses", 32'(quiet_bad), 32'(label) * 0);
  endtask

  initial begin
    seed_v = $urandom(32'd20240611);
    wait_chr(4);
    check(tx_char == 10'd0, "R10 reset char", 32'(tx_char), 32'd0);
    check(tx_stat == 1'b0, "R10 reset stat", 32'(tx_stat), 32'd0);
    @(negedge in_raw);
    rst = 1'b0;

    run_chars(150, 1'b0, 1'b1, 30);  // R1 R2 R4 R5
    run_chars(100, 1'b1, 1'b1, 30);  // R3
    run_chars(60, 1'b0, 1'b0, 10);

    // R6: self-test progress, then restart after disable
    wait_chr(LAT + 4);
    bist_en = 1'b1;
    bist_window(1100, 0);
    bist_en = 1'b0;
    wait_chr(3);
    bist_en = 1'b1;
    bist_window(520, 1);
    bist_en = 1'b0;
    wait_chr(4);
    check(tx_stat == 1'b0, "R6 idle after self-test", 32'(tx_stat), 32'd0);

    // R7: starve the buffer by withholding four input edges
    @(negedge in_raw);
    in_gate = 1'b0;
    repeat (4) @(negedge in_raw);
    in_gate = 1'b1;
    wait_chr(12);
    check(tx_stat == 1'b1, "R7 underflow flagged", 32'(tx_stat), 32'd1);
    wait_chr(30);
    check(tx_stat == 1'b1, "R7 underflow sticky", 32'(tx_stat), 32'd1);

    // R9: word-sync strobe clears the fault
    @(negedge chr_clk);
    wsync_done = 1'b1;
    @(negedge chr_clk);
    wsync_done = 1'b0;
    wait_chr(3);
    check(tx_stat == 1'b0, "R9 cleared by word sync", 32'(tx_stat), 32'd0);
    wait_chr(20);
    check(tx_stat == 1'b0, "R9 stays clear", 32'(tx_stat), 32'd0);

    // R10: reset re-centres, data path delay holds again
    do_reset();
    run_chars(60, 1'b0, 1'b1, 25);

    // R8: five extra input edges overflow the buffer
    repeat (5) begin
      @(negedge in_raw);
      #2 in_xtra = 1'b1;
      #4 in_xtra = 1'b0;
    end
    wait_chr(12);
    check(tx_stat == 1'b1, "R8 overflow flagged", 32'(tx_stat), 32'd1);

    // R11: held fault dominates the shared status under any traffic
    for (int k = 0; k < 20; k++) begin
      @(negedge in_raw);
      check(tx_stat == 1'b1, "R11 fault keeps status high", 32'(tx_stat), 32'd1);
      in_data = 10'($urandom_range(0, 1023));
      in_par  = 1'($urandom_range(0, 1));
    end
    in_data = 10'd0;
    in_par  = 1'b1;

    // R10: reset clears the sticky fault
    do_reset();
    wait_chr(20);
    check(tx_stat == 1'b0, "R10 fault cleared by reset", 32'(tx_stat), 32'd0);
    run_chars(40, 1'b0, 1'b0, 25);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #4_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule